// File: doc/BRIEF.md
# Redundant Feed Sequence Merger

The merger accepts two copies of the same market-data message stream, a primary and a secondary. Each message is a 288-bit word that travels with a 64-bit packet sequence number of the kind used by sequenced UDP market-data transports. The block emits a single gap-free stream that carries each sequence number exactly once, in ascending order, at up to one message per clock.

A global next-expected sequence counter decides every move. A feed whose head message matches the counter is forwarded. A head below the counter is a stale copy and is discarded without being forwarded. A head above the counter waits in its feed's holding slot, and the feed is back-pressured, until the other feed supplies the missing numbers. When both heads match in the same cycle, the primary copy is sent and the secondary copy is discarded. Each feed has one forwarded counter and one discarded counter, readable at plain output pins. Gap recovery, retransmission and packet framing are left to other blocks.

All three streams use valid/ready. A word moves on a clock edge where both valid and ready are high. On the inputs, ready depends on the feed's own holding slot and, through it, on `out_ready`. A producer must hold valid, sequence and data steady until the transfer happens. On the output, a presented word stays unchanged until it is taken.

Top module: `feed_seq_arbiter`

## Requirements
- R1: While `rst` is high at a clock edge, the output stream empties, all four diagnostic counters clear, both input ready pins go high, and the next-expected number loads from `init_seq`.
- R2: Output sequence numbers start at the `init_seq` value and rise by exactly one per transfer. A message is forwarded only when its sequence number equals the next-expected value.
- R3: A message whose sequence number is below the next-expected value is discarded and never appears at the output. Its feed's discard counter rises by one.
- R4: A message whose sequence number is above the next-expected value stays in its feed's slot, and that feed's ready is held low, until the number becomes expected. It is then forwarded, or it is discarded if the other feed forwarded that number first.
- R5: When both feed slots hold the expected number in the same cycle, the primary copy is forwarded with its data, and the secondary copy is discarded in that same cycle.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_seq` and `out_data` hold their values.
- R7: With `out_ready` held high, a matching message accepted on an input at clock edge n is presented on the output from edge n+1, two cycles after it was offered. A feed sending back to back keeps ready high and gets one output per clock.
- R8: `pri_fwd_cnt`/`sec_fwd_cnt` count the messages forwarded from each feed, and `pri_drop_cnt`/`sec_drop_cnt` count the messages discarded from each feed. In a test run, each feed's forwarded count plus its discarded count equals the number of messages that feed delivered.
- R9: The 288-bit data word of a forwarded message reaches `out_data` unchanged, paired with its own sequence number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| init_seq | input | 64 | Next-expected sequence number loaded during reset |
| pri_valid | input | 1 | Primary feed word valid |
| pri_ready | output | 1 | Primary feed may transfer |
| pri_seq | input | 64 | Primary feed sequence number |
| pri_data | input | 288 | Primary feed message word |
| sec_valid | input | 1 | Secondary feed word valid |
| sec_ready | output | 1 | Secondary feed may transfer |
| sec_seq | input | 64 | Secondary feed sequence number |
| sec_data | input | 288 | Secondary feed message word |
| out_valid | output | 1 | Merged stream word valid |
| out_ready | input | 1 | Merged stream consumer ready |
| out_seq | output | 64 | Sequence number of the presented word |
| out_data | output | 288 | Presented message word |
| pri_fwd_cnt | output | 32 | Messages forwarded from the primary feed |
| pri_drop_cnt | output | 32 | Messages discarded from the primary feed |
| sec_fwd_cnt | output | 32 | Messages forwarded from the secondary feed |
| sec_drop_cnt | output | 32 | Messages discarded from the secondary feed |

## Verification
If the next-expected counter is wrong, the error appears at the ports within a cycle or two. Either the output sequence skips or repeats a number, or a feed's ready stays low forever on a slot that should have been released. If a slot is classified wrongly, the forwarded/discarded split changes at once, which the sweep over every pair of offsets around the expected value exposes. If the tie-break is wrong, the secondary's feed tag appears in the data word of an output that the primary should have supplied. A broken output hold corrupts the word within the first stalled cycle.

// File: rtl/feed_arb_pkg.sv
package feed_arb_pkg;
  typedef enum logic [1:0] {
    CLS_EMPTY = 2'd0,
    CLS_STALE = 2'd1,
    CLS_MATCH = 2'd2,
    CLS_AHEAD = 2'd3
  } seq_cls_e;
endpackage

// File: rtl/seq_feed_slot.sv
module seq_feed_slot #(
  parameter int SEQ_W  = 64,
  parameter int DATA_W = 288
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [SEQ_W-1:0]  in_seq,
  input  logic [DATA_W-1:0] in_data,
  output logic              slot_valid,
  output logic [SEQ_W-1:0]  slot_seq,
  output logic [DATA_W-1:0] slot_data,
  input  logic              consume
);
  // The slot frees itself in the same cycle it is consumed, so a steady feed keeps one word per clock.
  assign in_ready = !slot_valid || consume;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_valid <= 1'b0;
    end else if (in_ready) begin
      slot_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (in_ready && in_valid) begin
      slot_seq  <= in_seq;
      slot_data <= in_data;
    end
  end

  // R4: a word that is neither forwarded nor discarded stays put
  a_r4_slot_hold: assert property (@(posedge clk) disable iff (rst)
    (slot_valid && !consume) |=> (slot_valid && $stable(slot_seq) && $stable(slot_data)));
endmodule

// File: rtl/seq_pick.sv
module seq_pick
  import feed_arb_pkg::*;
#(
  parameter int SEQ_W = 64
) (
  input  logic [SEQ_W-1:0] expect_seq,
  input  logic             p_valid,
  input  logic [SEQ_W-1:0] p_seq,
  input  logic             s_valid,
  input  logic [SEQ_W-1:0] s_seq,
  input  logic             out_free,
  output logic             p_fwd,
  output logic             p_drop,
  output logic             s_fwd,
  output logic             s_drop
);
  function automatic seq_cls_e classify(input logic v, input logic [SEQ_W-1:0] s,
                                        input logic [SEQ_W-1:0] e);
    if (!v)         return CLS_EMPTY;
    else if (s < e) return CLS_STALE;
    else if (s == e) return CLS_MATCH;
    else            return CLS_AHEAD;
  endfunction

  seq_cls_e p_cls, s_cls;

  always_comb begin
    p_cls  = classify(p_valid, p_seq, expect_seq);
    s_cls  = classify(s_valid, s_seq, expect_seq);
    p_fwd  = (p_cls == CLS_MATCH) && out_free;
    s_fwd  = (s_cls == CLS_MATCH) && (p_cls != CLS_MATCH) && out_free;
    p_drop = (p_cls == CLS_STALE);
    // the secondary copy of a number the primary is sending this cycle is already stale
    s_drop = (s_cls == CLS_STALE) || ((s_cls == CLS_MATCH) && p_fwd);
  end
endmodule

// File: rtl/seq_out_stage.sv
module seq_out_stage #(
  parameter int SEQ_W  = 64,
  parameter int DATA_W = 288
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [SEQ_W-1:0]  load_seq,
  input  logic [DATA_W-1:0] load_data,
  output logic              free,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [SEQ_W-1:0]  out_seq,
  output logic [DATA_W-1:0] out_data
);
  assign free = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (free) begin
      out_valid <= load;
    end
  end

  always_ff @(posedge clk) begin
    if (free && load) begin
      out_seq  <= load_seq;
      out_data <= load_data;
    end
  end

  // R6: a stalled output word is frozen
  a_r6_out_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_seq) && $stable(out_data)));
endmodule

// File: rtl/feed_seq_arbiter.sv
module feed_seq_arbiter #(
  parameter int SEQ_W  = 64,
  parameter int DATA_W = 288,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SEQ_W-1:0]  init_seq,
  input  logic              pri_valid,
  output logic              pri_ready,
  input  logic [SEQ_W-1:0]  pri_seq,
  input  logic [DATA_W-1:0] pri_data,
  input  logic              sec_valid,
  output logic              sec_ready,
  input  logic [SEQ_W-1:0]  sec_seq,
  input  logic [DATA_W-1:0] sec_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [SEQ_W-1:0]  out_seq,
  output logic [DATA_W-1:0] out_data,
  output logic [CNT_W-1:0]  pri_fwd_cnt,
  output logic [CNT_W-1:0]  pri_drop_cnt,
  output logic [CNT_W-1:0]  sec_fwd_cnt,
  output logic [CNT_W-1:0]  sec_drop_cnt
);
  localparam int NFEED = 2;
  localparam int PRI   = 0;
  localparam int SEC   = 1;

  logic              in_v   [NFEED];
  logic              in_r   [NFEED];
  logic [SEQ_W-1:0]  in_s   [NFEED];
  logic [DATA_W-1:0] in_d   [NFEED];
  logic              slot_v [NFEED];
  logic [SEQ_W-1:0]  slot_s [NFEED];
  logic [DATA_W-1:0] slot_d [NFEED];
  logic              fwd    [NFEED];
  logic              drop   [NFEED];
  logic [CNT_W-1:0]  fwd_cnt  [NFEED];
  logic [CNT_W-1:0]  drop_cnt [NFEED];

  logic [SEQ_W-1:0]  expect_seq;
  logic              out_free;
  logic              load;
  logic [SEQ_W-1:0]  load_seq;
  logic [DATA_W-1:0] load_data;

  assign in_v[PRI] = pri_valid;
  assign in_s[PRI] = pri_seq;
  assign in_d[PRI] = pri_data;
  assign in_v[SEC] = sec_valid;
  assign in_s[SEC] = sec_seq;
  assign in_d[SEC] = sec_data;
  assign pri_ready = in_r[PRI];
  assign sec_ready = in_r[SEC];

  for (genvar g = 0; g < NFEED; g++) begin : g_feed
    logic consume;
    assign consume = fwd[g] || drop[g];

    seq_feed_slot #(.SEQ_W(SEQ_W), .DATA_W(DATA_W)) u_slot (
      .clk        (clk),
      .rst        (rst),
      .in_valid   (in_v[g]),
      .in_ready   (in_r[g]),
      .in_seq     (in_s[g]),
      .in_data    (in_d[g]),
      .slot_valid (slot_v[g]),
      .slot_seq   (slot_s[g]),
      .slot_data  (slot_d[g]),
      .consume    (consume)
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        fwd_cnt[g]  <= '0;
        drop_cnt[g] <= '0;
      end else begin
        if (fwd[g])  fwd_cnt[g]  <= fwd_cnt[g] + 1'b1;
        if (drop[g]) drop_cnt[g] <= drop_cnt[g] + 1'b1;
      end
    end
  end

  seq_pick #(.SEQ_W(SEQ_W)) u_pick (
    .expect_seq (expect_seq),
    .p_valid    (slot_v[PRI]),
    .p_seq      (slot_s[PRI]),
    .s_valid    (slot_v[SEC]),
    .s_seq      (slot_s[SEC]),
    .out_free   (out_free),
    .p_fwd      (fwd[PRI]),
    .p_drop     (drop[PRI]),
    .s_fwd      (fwd[SEC]),
    .s_drop     (drop[SEC])
  );

  assign load      = fwd[PRI] || fwd[SEC];
  assign load_seq  = fwd[PRI] ? slot_s[PRI] : slot_s[SEC];
  assign load_data = fwd[PRI] ? slot_d[PRI] : slot_d[SEC];

  always_ff @(posedge clk) begin
    if (rst)       expect_seq <= init_seq;
    else if (load) expect_seq <= expect_seq + 1'b1;
  end

  seq_out_stage #(.SEQ_W(SEQ_W), .DATA_W(DATA_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .load_seq  (load_seq),
    .load_data (load_data),
    .free      (out_free),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_seq   (out_seq),
    .out_data  (out_data)
  );

  assign pri_fwd_cnt  = fwd_cnt[PRI];
  assign pri_drop_cnt = drop_cnt[PRI];
  assign sec_fwd_cnt  = fwd_cnt[SEC];
  assign sec_drop_cnt = drop_cnt[SEC];

  // Tracker of the last delivered number, used only by the ordering check.
  logic             seen_out;
  logic [SEQ_W-1:0] last_out;
  always_ff @(posedge clk) begin
    if (rst) begin
      seen_out <= 1'b0;
      last_out <= '0;
    end else if (out_valid && out_ready) begin
      seen_out <= 1'b1;
      last_out <= out_seq;
    end
  end

  // R2: consecutive deliveries differ by exactly one
  a_r2_in_order: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && seen_out) |-> (out_seq == last_out + 1'b1));

  // R5: on a tie the primary word reaches the output
  a_r5_primary_wins: assert property (@(posedge clk) disable iff (rst)
    (slot_v[PRI] && slot_v[SEC] && slot_s[PRI] == expect_seq && slot_s[SEC] == expect_seq && out_free)
    |=> (out_valid && out_data == $past(slot_d[PRI])));

  // R3: a stale slot never feeds the output register
  a_r3_stale_not_sent: assert property (@(posedge clk) disable iff (rst)
    (slot_v[SEC] && slot_s[SEC] < expect_seq) |-> !fwd[SEC]);

  // R7: an empty slot always accepts
  a_r7_empty_ready: assert property (@(posedge clk) disable iff (rst)
    (!slot_v[PRI] |-> pri_ready) and (!slot_v[SEC] |-> sec_ready));
endmodule

// File: tb/feed_seq_arbiter_bench.sv
module feed_seq_arbiter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [63:0]  init_seq = '0;
  logic         pri_valid = 1'b0, sec_valid = 1'b0, out_ready = 1'b1;
  logic [63:0]  pri_seq = '0, sec_seq = '0;
  logic [287:0] pri_data = '0, sec_data = '0;
  logic         pri_ready, sec_ready, out_valid;
  logic [63:0]  out_seq;
  logic [287:0] out_data;
  logic [31:0]  pri_fwd_cnt, pri_drop_cnt, sec_fwd_cnt, sec_drop_cnt;

  feed_seq_arbiter u_feed_seq_arbiter (
    .clk(clk), .rst(rst), .init_seq(init_seq),
    .pri_valid(pri_valid), .pri_ready(pri_ready), .pri_seq(pri_seq), .pri_data(pri_data),
    .sec_valid(sec_valid), .sec_ready(sec_ready), .sec_seq(sec_seq), .sec_data(sec_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_seq(out_seq), .out_data(out_data),
    .pri_fwd_cnt(pri_fwd_cnt), .pri_drop_cnt(pri_drop_cnt),
    .sec_fwd_cnt(sec_fwd_cnt), .sec_drop_cnt(sec_drop_cnt)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  logic [63:0]  got_seq  [256];
  logic [287:0] got_data [256];
  int           got_cyc  [256];
  int           got_n = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !done) begin
      errors++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected below %0d", cyc, WATCHDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (!rst && out_valid && out_ready) begin
      got_seq[got_n % 256]  = out_seq;
      got_data[got_n % 256] = out_data;
      got_cyc[got_n % 256]  = cyc;
      got_n++;
    end
  end

  function automatic logic [287:0] mk(input int feed, input logic [63:0] s);
    return {32'(feed + 1), s, ~s, s * 64'd7, s + 64'd1};
  endfunction

  task automatic check(input string req, input string what, input logic [287:0] act,
                       input logic [287:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic [63:0] v);
    @(posedge clk); #1;
    rst = 1'b1; init_seq = v; pri_valid = 0; sec_valid = 0;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  task automatic send_pri(input logic [63:0] s);
    pri_valid = 1; pri_seq = s; pri_data = mk(0, s);
    forever begin @(negedge clk); if (pri_ready) break; end
    @(posedge clk); #1 pri_valid = 0;
  endtask

  task automatic send_sec(input logic [63:0] s);
    sec_valid = 1; sec_seq = s; sec_data = mk(1, s);
    forever begin @(negedge clk); if (sec_ready) break; end
    @(posedge clk); #1 sec_valid = 0;
  endtask

  bit stream_on = 0;

  initial begin
    int base;
    // R1: reset state
    do_reset(64'd7);
    @(negedge clk);
    check("R1", "out_valid", 288'(out_valid), 288'd0);
    check("R1", "counters", 288'({pri_fwd_cnt, pri_drop_cnt, sec_fwd_cnt, sec_drop_cnt}), 288'd0);
    check("R1", "ready pins", 288'({pri_ready, sec_ready}), 288'd3);

    // Sweep of every offset pair around the expected value (R2 R3 R4 R5 R8 R9)
    for (int dp = -2; dp <= 2; dp++) begin
      for (int ds = -2; ds <= 2; ds++) begin
        longint e, p, s;
        int pf, pd, sf, sd, src;
        bit pa, sa;
        do_reset(64'd100);
        base = got_n;
        p = 100 + dp; s = 100 + ds;
        @(posedge clk); #1;
        pri_valid = 1; pri_seq = 64'(p); pri_data = mk(0, 64'(p));
        sec_valid = 1; sec_seq = 64'(s); sec_data = mk(1, 64'(s));
        @(posedge clk); #1;
        pri_valid = 0; sec_valid = 0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        e = 100; pf = 0; pd = 0; sf = 0; sd = 0; pa = 1; sa = 1;
        src = (p == 100) ? 0 : 1;
        for (int k = 0; k < 4; k++) begin
          if (pa && p < e) begin pd++; pa = 0; end
          if (sa && s < e) begin sd++; sa = 0; end
          if (pa && p == e) begin
            pf++; pa = 0; e++;
            if (sa && s == e - 1) begin sd++; sa = 0; end
          end else if (sa && s == e) begin
            sf++; sa = 0; e++;
          end
        end
        check("R8", "pri forwarded", 288'(pri_fwd_cnt), 288'(pf));
        check("R3", "pri discarded", 288'(pri_drop_cnt), 288'(pd));
        check("R8", "sec forwarded", 288'(sec_fwd_cnt), 288'(sf));
        check("R5", "sec discarded", 288'(sec_drop_cnt), 288'(sd));
        check("R2", "output count", 288'(got_n - base), 288'(pf + sf));
        check("R4", "held ready pins", 288'({pri_ready, sec_ready}), 288'({!pa, !sa}));
        for (int i = 0; i < pf + sf; i++)
          check("R2", "output sequence", 288'(got_seq[(base + i) % 256]), 288'(100 + i));
        if (pf + sf > 0)
          check("R9", "first output data", got_data[base % 256], mk(src, 64'd100));
      end
    end

    // R6 output hold under back-pressure, R4 slot back-pressure
    do_reset(64'd0);
    base = got_n;
    out_ready = 0;
    send_pri(64'd0);
    send_pri(64'd1);
    fork
      send_pri(64'd2);
      begin
        @(negedge clk);
        check("R4", "pri_ready while stalled", 288'(pri_ready), 288'd0);
        for (int i = 0; i < 3; i++) begin
          @(negedge clk);
          check("R6", "out_valid held", 288'(out_valid), 288'd1);
          check("R6", "out_seq held", 288'(out_seq), 288'd0);
          check("R6", "out_data held", out_data, mk(0, 64'd0));
        end
        @(posedge clk); #1 out_ready = 1;
      end
    join
    repeat (6) @(posedge clk);
    @(negedge clk);
    check("R6", "outputs after release", 288'(got_n - base), 288'd3);
    for (int i = 0; i < 3; i++)
      check("R6", "released sequence", 288'(got_seq[(base + i) % 256]), 288'(i));
    check("R8", "pri forwarded after release", 288'(pri_fwd_cnt), 288'd3);

    // R7 latency and one word per clock
    do_reset(64'd50);
    base = got_n;
    begin
      int c0;
      @(posedge clk); #1;
      c0 = cyc;
      for (int i = 0; i < 10; i++) send_pri(64'(50 + i));
      repeat (4) @(posedge clk);
      @(negedge clk);
      check("R7", "burst outputs", 288'(got_n - base), 288'd10);
      for (int i = 0; i < 10; i++) begin
        check("R7", "output cycle", 288'(got_cyc[(base + i) % 256]), 288'(c0 + 2 + i));
        check("R9", "burst data", got_data[(base + i) % 256], mk(0, 64'(50 + i)));
      end
    end

    // R2 R8 interleaved redundant streams with gaps on each side and a stuttering consumer
    do_reset(64'd0);
    base = got_n;
    stream_on = 1;
    fork
      while (stream_on) begin @(posedge clk); #1 out_ready = (cyc % 3 != 0); end
    join_none
    fork
      for (int s = 0; s < 30; s++) if (s % 5 != 3) send_pri(64'(s));
      for (int s = 0; s < 30; s++) if (s % 5 != 1) send_sec(64'(s));
    join
    stream_on = 0;
    repeat (3) @(posedge clk);
    #1 out_ready = 1;
    repeat (20) @(posedge clk);
    @(negedge clk);
    check("R2", "merged count", 288'(got_n - base), 288'd30);
    for (int i = 0; i < 30; i++) begin
      logic [287:0] gd;
      gd = got_data[(base + i) % 256];
      check("R2", "merged sequence", 288'(got_seq[(base + i) % 256]), 288'(i));
      check("R9", "merged payload", 288'(gd[255:0]), 288'(mk(0, 64'(i)) & {32'd0, {256{1'b1}}}));
    end
    check("R8", "forwarded total", 288'(pri_fwd_cnt + sec_fwd_cnt), 288'd30);
    check("R8", "pri accounted", 288'(pri_fwd_cnt + pri_drop_cnt), 288'd24);
    check("R8", "sec accounted", 288'(sec_fwd_cnt + sec_drop_cnt), 288'd24);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule